// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator with Set/Clear Enables

This block collects a vector of peripheral interrupt lines, by default 32 of them, and drives one interrupt request towards a processor. Each line is level-sensitive. It passes through a two-stage synchronizer and then takes part in the request whenever its enable bit is set. Nothing has to be acknowledged. A source stays visible for as long as its peripheral holds it high.

Software reaches the block over a simple single-cycle register bus with a select, a write strobe, a word address, write data and registered read data. Enable bits never change through a read-modify-write. Software sets them through one address and clears them through another, and in both cases only the bits written as one are affected. Software can read the raw line levels and the masked status at separate addresses. An interrupt handler therefore reads the masked word, services its lowest set bit, and reads again until the word is zero.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: Source line n maps to bit n of every status and enable word, for all N_SRC lines (default 32).
- R2: A read of offset 0x0 returns masked status, which is each synchronized source level ANDed with its enable bit.
- R3: A read of offset 0x4 returns the synchronized level of every source, whatever its enable bit.
- R4: A write to offset 0x8 sets the enable bit for every 1 in the write data, and leaves the enable bits written as 0 unchanged.
- R5: A write to offset 0xC clears the enable bit for every 1 in the write data, and leaves the bits written as 0 unchanged. Writing all ones clears every enable in a single access.
- R6: After reset all enable bits are 0, irq_o is low and rdata_o is zero.
- R7: irq_o is a register holding the OR of the masked status. It rises one clock after masked status becomes nonzero, and it falls one clock after the last enabled source drops or is disabled.
- R8: A change on a source line reaches raw status after two clock edges, so a read is the first to show it when it is captured at the third edge after the change.
- R9: A read of offset 0x8 or 0xC returns the current enable register.
- R10: A read of any other offset returns zero, and a write to any other offset changes no enable bit.
- R11: Status needs no acknowledge. A read has no side effect, and a masked bit stays set while its line is high and enabled. The bit clears once the line drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | N_SRC | Asynchronous level interrupt lines from the peripherals |
| sel_i | input | 1 | Bus transfer valid for this cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, registered at the edge that accepts the read |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
Read data is due one edge after the bus read is accepted. A source change first appears in a read captured at the third edge after it. An enable write affects a masked read accepted at the next edge, and it affects irq_o one edge after that. The bench issues each transfer at a falling edge. It queues the expected word as the transfer starts, and the monitor compares that word two nanoseconds after the capturing rising edge. The bench checks irq_o at falling edges that it counts explicitly from the stimulus, both before and after the edge where the request is due to change. This confirms the single register of delay in both directions.

// File: rtl/lic_pkg.sv
package lic_pkg;
  parameter int unsigned N_SRC_DEF  = 32;
  parameter int unsigned ADDR_W_DEF = 12;
  parameter int unsigned DATA_W_DEF = 32;
  parameter int unsigned SYNC_DEPTH = 2;

  localparam logic [ADDR_W_DEF-1:0] OFF_MASKED = 'h0;
  localparam logic [ADDR_W_DEF-1:0] OFF_RAW    = 'h4;
  localparam logic [ADDR_W_DEF-1:0] OFF_EN_SET = 'h8;
  localparam logic [ADDR_W_DEF-1:0] OFF_EN_CLR = 'hC;

  typedef enum logic [2:0] {
    RS_MASKED,
    RS_RAW,
    RS_EN_SET,
    RS_EN_CLR,
    RS_NONE
  } reg_sel_e;
endpackage

// File: rtl/lic_sync.sv
module lic_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/lic_enable.sv
module lic_enable #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q;
  logic [W-1:0] set_v;
  logic [W-1:0] clr_v;

  always_comb begin
    set_v = set_stb ? bits_i : '0;
    clr_v = clr_stb ? bits_i : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= (en_q | set_v) & ~clr_v;
  end

  assign en_o = en_q;
endmodule

// File: rtl/lic_regbus.sv
module lic_regbus
  import lic_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_SRC-1:0]  raw_i,
  input  logic [N_SRC-1:0]  en_i,
  output logic              set_stb,
  output logic              clr_stb,
  output logic [DATA_W-1:0] rdata_o
);
  reg_sel_e     rsel;
  logic [N_SRC-1:0]  rd_word;
  logic [DATA_W-1:0] rd_wide;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    unique case (addr_i)
      ADDR_W'(OFF_MASKED): rsel = RS_MASKED;
      ADDR_W'(OFF_RAW):    rsel = RS_RAW;
      ADDR_W'(OFF_EN_SET): rsel = RS_EN_SET;
      ADDR_W'(OFF_EN_CLR): rsel = RS_EN_CLR;
      default:             rsel = RS_NONE;
    endcase
  end

  assign set_stb = sel_i && wr_i && (rsel == RS_EN_SET);
  assign clr_stb = sel_i && wr_i && (rsel == RS_EN_CLR);

  always_comb begin
    case (rsel)
      RS_MASKED:           rd_word = raw_i & en_i;
      RS_RAW:              rd_word = raw_i;
      RS_EN_SET, RS_EN_CLR: rd_word = en_i;
      default:             rd_word = '0;
    endcase
    rd_wide = '0;
    rd_wide[N_SRC-1:0] = rd_word;
  end

  always_ff @(posedge clk) begin
    if (rst)                rdata_q <= '0;
    else if (sel_i && !wr_i) rdata_q <= rd_wide;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lic_pkg::*;
#(
  parameter int unsigned N_SRC  = N_SRC_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [N_SRC-1:0] raw_lvl;
  logic [N_SRC-1:0] en_q;
  logic             set_stb;
  logic             clr_stb;
  logic             irq_q;

  lic_sync #(.W(N_SRC), .STAGES(SYNC_DEPTH)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (src_i),
    .sync_o  (raw_lvl)
  );

  lic_enable #(.W(N_SRC)) u_en (
    .clk     (clk),
    .rst     (rst),
    .set_stb (set_stb),
    .clr_stb (clr_stb),
    .bits_i  (wdata_i[N_SRC-1:0]),
    .en_o    (en_q)
  );

  lic_regbus #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk     (clk),
    .rst     (rst),
    .sel_i   (sel_i),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .raw_i   (raw_lvl),
    .en_i    (en_q),
    .set_stb (set_stb),
    .clr_stb (clr_stb),
    .rdata_o (rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(raw_lvl & en_q);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/lic_checker.sv
module lic_checker #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [N_SRC-1:0]  src_i,
  input logic              sel_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic [N_SRC-1:0]  raw_lvl,
  input logic [N_SRC-1:0]  en_q
);
  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst)               age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  logic wr_set, wr_clr, rd_mask, rd_raw, rd_other, mapped;
  assign mapped   = (addr_i == ADDR_W'('h0)) || (addr_i == ADDR_W'('h4)) ||
                    (addr_i == ADDR_W'('h8)) || (addr_i == ADDR_W'('hC));
  assign wr_set   = sel_i && wr_i && (addr_i == ADDR_W'('h8));
  assign wr_clr   = sel_i && wr_i && (addr_i == ADDR_W'('hC));
  assign rd_mask  = sel_i && !wr_i && (addr_i == ADDR_W'('h0));
  assign rd_raw   = sel_i && !wr_i && (addr_i == ADDR_W'('h4));
  assign rd_other = sel_i && !wr_i && !mapped;

  logic [N_SRC-1:0] wbits;
  assign wbits = wdata_i[N_SRC-1:0];

  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> (en_q == '0 && !irq_o && rdata_o == '0)); // R6
  AST_SET_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_set |=> ((en_q & $past(wbits)) == $past(wbits))); // R4
  AST_CLR_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> ((en_q & $past(wbits)) == '0)); // R5
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_set || wr_clr) |=> $stable(en_q)); // R10
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
    (|(raw_lvl & en_q)) |=> irq_o); // R7
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (rst)
    !(|(raw_lvl & en_q)) |=> !irq_o); // R7
  AST_RAW_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd3) |-> (raw_lvl == $past(src_i, 2))); // R8
  AST_MASKED_READ: assert property (@(posedge clk) disable iff (rst)
    rd_mask |=> (rdata_o[N_SRC-1:0] == $past(raw_lvl & en_q))); // R2
  AST_RAW_READ: assert property (@(posedge clk) disable iff (rst)
    rd_raw |=> (rdata_o[N_SRC-1:0] == $past(raw_lvl))); // R3
  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (rst)
    rd_other |=> (rdata_o == '0)); // R10
endmodule

bind lvl_irq_ctrl lic_checker #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .src_i   (src_i),
  .sel_i   (sel_i),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .raw_lvl (raw_lvl),
  .en_q    (en_q)
);

// File: tb/lvl_irq_ctrl_tb_top.sv
module lvl_irq_ctrl_tb_top;
  localparam int unsigned NS = 32;
  localparam int unsigned AW = 12;
  localparam int unsigned DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] src = '0;
  logic          sel = 1'b0;
  logic          wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lvl_irq_ctrl #(.N_SRC(NS), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .src_i(src), .sel_i(sel), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  typedef struct {
    logic [DW-1:0] val;
    string         tag;
  } exp_t;
  exp_t sb_q[$];

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
    exp_t it;
    it.val = e; it.tag = tag;
    sb_q.push_back(it);
    sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    n_cmp++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s irq_o actual=%b expected=%b", tag, irq, e);
    end
  endtask

  // monitor: compares read data after the capturing edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (!rst && sel && !wr) begin
        exp_t it;
        n_cmp++;
        if (sb_q.size() == 0) begin
          n_bad++;
          $display("FAIL scoreboard: read with no expectation actual=%h expected=none", rdata);
        end else begin
          it = sb_q.pop_front();
          if (rdata !== it.val) begin
            n_bad++;
            $display("FAIL %s rdata actual=%h expected=%h", it.tag, rdata, it.val);
          end
        end
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R6: reset state
    n_cmp++;
    if (rdata !== '0) begin
      n_bad++;
      $display("FAIL R6 rdata after reset actual=%h expected=0", rdata);
    end
    chk_irq(1'b0, "R6 reset");
    bus_rd('h8, 32'h0, "R6/R9 enable after reset");
    bus_rd('h0, 32'h0, "R6 masked after reset");

    // R1/R3: raw levels, bit n = source n, independent of enables
    src = 32'hA5A5_0003;
    repeat (3) @(negedge clk);
    bus_rd('h4, 32'hA5A5_0003, "R1/R3 raw status");
    bus_rd('h0, 32'h0, "R2 masked with no enables");
    chk_irq(1'b0, "R6 no enable no irq");

    // R4: set enables, R7 registered irq
    bus_wr('h8, 32'h0000_0001);
    chk_irq(1'b0, "R7 irq one edge late");
    bus_rd('h8, 32'h0000_0001, "R4/R9 set bit0");
    chk_irq(1'b1, "R7 irq rises");
    bus_wr('h8, 32'h8000_0000);
    bus_rd('h8, 32'h8000_0001, "R4 zeros leave bits unchanged");
    bus_rd('h0, 32'h8000_0001, "R2 masked status");

    // R5: clear
    bus_wr('hC, 32'h0000_0001);
    bus_rd('hC, 32'h8000_0000, "R5/R9 clear bit0");
    bus_rd('h0, 32'h8000_0000, "R2 masked after clear");

    // R7/R8: source drop reaches irq three edges later
    src = 32'h25A5_0003;
    repeat (2) @(negedge clk);
    chk_irq(1'b1, "R8 irq holds through sync");
    @(negedge clk);
    chk_irq(1'b0, "R7 irq falls after source drop");

    // R8: raw latency
    src = 32'h25A5_0007;
    bus_rd('h4, 32'h25A5_0003, "R8 raw edge1 old");
    bus_rd('h4, 32'h25A5_0003, "R8 raw edge2 old");
    bus_rd('h4, 32'h25A5_0007, "R8 raw edge3 new");

    // R10: unmapped offsets
    bus_wr('h10, 32'hFFFF_FFFF);
    bus_wr('h6, 32'hFFFF_FFFF);
    bus_rd('h8, 32'h8000_0000, "R10 unmapped write ignored");
    bus_rd('h10, 32'h0, "R10 unmapped read 0x10");
    bus_rd('h6, 32'h0, "R10 unaligned read 0x6");
    chk_irq(1'b0, "R10 irq unchanged");

    // R5: clear all in one access
    bus_wr('h8, 32'hFFFF_FFFF);
    bus_rd('h0, 32'h25A5_0007, "R2 masked all enabled");
    chk_irq(1'b1, "R7 irq with all enabled");
    bus_wr('hC, 32'hFFFF_FFFF);
    chk_irq(1'b1, "R7 irq still registered");
    bus_rd('hC, 32'h0, "R5 all cleared");
    chk_irq(1'b0, "R5 irq falls after clear-all");
    bus_rd('h0, 32'h0, "R5 masked zero");

    // R11: level held, reads have no side effect, clears on line drop
    bus_wr('h8, 32'h0000_0002);
    bus_rd('h0, 32'h0000_0002, "R11 level read 1");
    bus_rd('h0, 32'h0000_0002, "R11 level read 2");
    bus_rd('h0, 32'h0000_0002, "R11 level read 3");
    chk_irq(1'b1, "R11 irq held");
    src = 32'h25A5_0005;
    repeat (2) @(negedge clk);
    bus_rd('h0, 32'h0, "R11 clears on line drop");
    chk_irq(1'b0, "R11 irq clears on line drop");

    repeat (3) @(negedge clk);
    n_cmp++;
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", sb_q.size());
    end
    done = 1;
    summary();
    $finish;
  end
endmodule